// File: doc/BRIEF.md
# Doorbell Circular Queue Tracker

This block keeps the pointer state for a set of paired circular queues in a storage controller. Each pair has a submission ring and a completion ring. The host owns one pointer of each ring, and the controller's own logic owns the other. The host publishes new commands by writing a submission tail doorbell, and the controller consumes them by stepping the submission head. The controller posts results by stepping the completion tail, and the host releases them by writing a completion head doorbell.

Doorbells arrive on a simple register-write port as a byte address and a 16-bit value. A doorbell value is accepted only when it names a slot inside the ring and moves the host's pointer in a way the ring can hold. Any other value is dropped, and a sticky error flag is raised. Ring sizes come from a configuration port that stores a zero-based entry count for each pair. Queue 0 is the admin pair and has a smaller size limit than the I/O pairs. For every ring the block reports empty and full flags. An observation port reads the four pointers of any selected pair.

Top module: `dbq_tracker`

## Requirements
- R1: After a synchronous reset, every pointer reads 0, every ring holds 2 entries, every ring reads empty and not full, and both error flags are 0.
- R2: A configuration write for queue q with legal zero-based sizes S and C makes the submission ring S+1 entries and the completion ring C+1 entries, and clears all four pointers of pair q.
- R3: A configuration write is illegal, and is dropped with `cfg_err` set (sticky until reset), when either zero-based size is 0, when the queue index is not below NUM_Q, or when the queue is 0 and either size exceeds 4095. I/O queues accept sizes up to 65535.
- R4: Doorbells sit at byte address 0x1000 + 16*q + 8*k, where k=0 is the submission tail of pair q and k=1 is its completion head. Writes to any other address, including addresses that are not 8-byte aligned, change nothing and raise no error.
- R5: A submission tail doorbell with value v is accepted when v < entries and the ring distance from the head to v is at least the current occupancy. Accepted values become the tail.
- R6: A completion head doorbell with value v is accepted when v < entries and the ring distance from the head to v is at most the current occupancy. Accepted values become the head.
- R7: A doorbell that fails its check leaves every pointer unchanged and sets `db_err`, which stays set until reset.
- R8: `sq_pop` for queue q moves that submission head forward by one, wrapping to 0 after entries-1. It is ignored when the ring is empty.
- R9: `cq_push` for queue q moves that completion tail forward by one, wrapping to 0 after entries-1. It is ignored when the ring is full.
- R10: A ring reads empty when its head equals its tail and full when its occupancy equals entries-1. It is never both at once.
- R11: Every accepted event appears on the flags, the observation outputs and the error flags after exactly one rising clock edge. The observation outputs follow `obs_qid` combinationally.
- R12: In one cycle, a configuration write to pair q takes priority over any doorbell or step for pair q, and those are dropped without error. A doorbell and a local step on the same ring in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue pair being configured |
| cfg_sq_qsize | input | 16 | Zero-based submission ring size |
| cfg_cq_qsize | input | 16 | Zero-based completion ring size |
| db_we | input | 1 | Doorbell write strobe |
| db_addr | input | ADDR_W | Doorbell byte address |
| db_data | input | 16 | Doorbell value |
| sq_pop | input | 1 | Controller consumed one submission entry |
| sq_pop_qid | input | QID_W | Queue of the consumed entry |
| cq_push | input | 1 | Controller posted one completion entry |
| cq_push_qid | input | QID_W | Queue of the posted entry |
| obs_qid | input | QID_W | Pair selected for observation |
| obs_sq_head | output | 16 | Submission head of the observed pair |
| obs_sq_tail | output | 16 | Submission tail of the observed pair |
| obs_cq_head | output | 16 | Completion head of the observed pair |
| obs_cq_tail | output | 16 | Completion tail of the observed pair |
| sq_empty | output | NUM_Q | Per-queue submission empty |
| sq_full | output | NUM_Q | Per-queue submission full |
| cq_empty | output | NUM_Q | Per-queue completion empty |
| cq_full | output | NUM_Q | Per-queue completion full |
| db_err | output | 1 | Sticky rejected-doorbell flag |
| cfg_err | output | 1 | Sticky rejected-configuration flag |

## Verification
All pointer and flag state is registered once, so every doorbell, step or configuration write driven before a rising edge has its effect due on the outputs after that same edge. The bench drives inputs just after each rising edge and compares on the falling edge that follows. Its reference model updates on the rising edge from the same inputs, so each comparison checks the state produced by the last edge. One directed check looks at the falling edge before the capturing edge and confirms that nothing moves early.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
    localparam int unsigned PTR_W = 16;
    localparam logic [PTR_W-1:0] ADMIN_MAX_ZB = 16'd4095;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [PTR_W:0]   dist_t;

    typedef struct packed {
        ptr_t size;   // zero-based entry count
        ptr_t head;
        ptr_t tail;
    } ring_t;

    typedef struct packed {
        logic db_err;
        logic cfg_err;
    } flags_t;
endpackage

// File: rtl/dbq_decode.sv
module dbq_decode #(
    parameter int unsigned NUM_Q  = 4,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned QID_W  = 2,
    parameter logic [ADDR_W-1:0] DB_BASE = ADDR_W'(32'h1000)
) (
    input  logic              db_we,
    input  logic [ADDR_W-1:0] db_addr,
    output logic              hit,
    output logic [QID_W-1:0]  qid,
    output logic              is_cq
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NUM_Q * 16);

    logic [ADDR_W-1:0] off;
    logic              in_range;
    logic              aligned;

    always_comb begin
        off      = db_addr - DB_BASE;
        in_range = (db_addr >= DB_BASE) && ({1'b0, off} < SPAN);
        aligned  = (db_addr[2:0] == 3'd0);
        hit      = db_we && in_range && aligned;
        qid      = off[QID_W+3:4];
        is_cq    = off[3];
    end
endmodule

// File: rtl/dbq_ring.sv
module dbq_ring
    import dbq_pkg::*;
#(
    parameter bit HOST_OWNS_TAIL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic resize,
    input  ptr_t new_size,
    input  logic host_we,
    input  ptr_t host_val,
    input  logic step,
    output ptr_t head,
    output ptr_t tail,
    output logic empty,
    output logic full,
    output logic host_reject
);
    ring_t st_q, st_d;
    dist_t occ, hdist;
    logic  in_range, host_ok, step_ok;

    function automatic dist_t ring_dist(input ptr_t a, input ptr_t b, input ptr_t sz);
        if (a >= b) return {1'b0, a} - {1'b0, b};
        return {1'b0, a} + {1'b0, sz} + dist_t'(1) - {1'b0, b};
    endfunction

    function automatic ptr_t ring_inc(input ptr_t p, input ptr_t sz);
        return (p == sz) ? '0 : p + ptr_t'(1);
    endfunction

    assign occ      = ring_dist(st_q.tail, st_q.head, st_q.size);
    assign hdist    = ring_dist(host_val, st_q.head, st_q.size);
    assign in_range = (host_val <= st_q.size);

    generate
        if (HOST_OWNS_TAIL) begin : g_host_tail
            // host may only add entries: new occupancy not below current
            assign host_ok = in_range && (hdist >= occ);
            assign step_ok = (occ != '0);
        end else begin : g_host_head
            // host may only free entries that are occupied
            assign host_ok = in_range && (hdist <= occ);
            assign step_ok = (occ != {1'b0, st_q.size});
        end
    endgenerate

    assign host_reject = host_we && !host_ok && !resize;

    always_comb begin
        st_d = st_q;
        if (resize) begin
            st_d.size = new_size;
            st_d.head = '0;
            st_d.tail = '0;
        end else if (HOST_OWNS_TAIL) begin
            if (host_we && host_ok) st_d.tail = host_val;
            if (step && step_ok)    st_d.head = ring_inc(st_q.head, st_q.size);
        end else begin
            if (host_we && host_ok) st_d.head = host_val;
            if (step && step_ok)    st_d.tail = ring_inc(st_q.tail, st_q.size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.size <= ptr_t'(1);
            st_q.head <= '0;
            st_q.tail <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign empty = (occ == '0);
    assign full  = (occ == {1'b0, st_q.size});

    assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q.head <= st_q.size) && (st_q.tail <= st_q.size));

    assert_not_empty_and_full_R10: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    generate
        if (HOST_OWNS_TAIL) begin : g_chk_sq
            assert_reject_keeps_tail_R7: assert property (@(posedge clk) disable iff (rst)
                host_reject |=> (tail == $past(tail)));
            assert_pop_on_empty_R8: assert property (@(posedge clk) disable iff (rst)
                (step && empty && !resize && !host_we) |=> (head == $past(head)));
        end else begin : g_chk_cq
            assert_reject_keeps_head_R7: assert property (@(posedge clk) disable iff (rst)
                host_reject |=> (head == $past(head)));
            assert_push_on_full_R9: assert property (@(posedge clk) disable iff (rst)
                (step && full && !resize && !host_we) |=> (tail == $past(tail)));
        end
    endgenerate
endmodule

// File: rtl/dbq_tracker.sv
module dbq_tracker
    import dbq_pkg::*;
#(
    parameter int unsigned NUM_Q  = 4,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    parameter logic [ADDR_W-1:0] DB_BASE = ADDR_W'(32'h1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [15:0]       cfg_sq_qsize,
    input  logic [15:0]       cfg_cq_qsize,
    input  logic              db_we,
    input  logic [ADDR_W-1:0] db_addr,
    input  logic [15:0]       db_data,
    input  logic              sq_pop,
    input  logic [QID_W-1:0]  sq_pop_qid,
    input  logic              cq_push,
    input  logic [QID_W-1:0]  cq_push_qid,
    input  logic [QID_W-1:0]  obs_qid,
    output logic [15:0]       obs_sq_head,
    output logic [15:0]       obs_sq_tail,
    output logic [15:0]       obs_cq_head,
    output logic [15:0]       obs_cq_tail,
    output logic [NUM_Q-1:0]  sq_empty,
    output logic [NUM_Q-1:0]  sq_full,
    output logic [NUM_Q-1:0]  cq_empty,
    output logic [NUM_Q-1:0]  cq_full,
    output logic              db_err,
    output logic              cfg_err
);
    localparam logic [QID_W:0] QCOUNT = (QID_W+1)'(NUM_Q);

    logic             db_hit, db_is_cq;
    logic [QID_W-1:0] db_qid;
    logic             cfg_ok;
    logic             obs_ok;

    ptr_t sq_head_a [NUM_Q];
    ptr_t sq_tail_a [NUM_Q];
    ptr_t cq_head_a [NUM_Q];
    ptr_t cq_tail_a [NUM_Q];
    logic [NUM_Q-1:0] sq_rej, cq_rej;

    flags_t fl_q, fl_d;

    dbq_decode #(
        .NUM_Q  (NUM_Q),
        .ADDR_W (ADDR_W),
        .QID_W  (QID_W),
        .DB_BASE(DB_BASE)
    ) u_decode (
        .db_we  (db_we),
        .db_addr(db_addr),
        .hit    (db_hit),
        .qid    (db_qid),
        .is_cq  (db_is_cq)
    );

    always_comb begin
        cfg_ok = (cfg_sq_qsize != '0) && (cfg_cq_qsize != '0)
              && ({1'b0, cfg_qid} < QCOUNT)
              && ((cfg_qid != '0)
                  || ((cfg_sq_qsize <= ADMIN_MAX_ZB) && (cfg_cq_qsize <= ADMIN_MAX_ZB)));
    end

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_pair
            logic resize_q;
            assign resize_q = cfg_we && cfg_ok && (cfg_qid == QID_W'(q));

            dbq_ring #(.HOST_OWNS_TAIL(1'b1)) u_sq (
                .clk        (clk),
                .rst        (rst),
                .resize     (resize_q),
                .new_size   (cfg_sq_qsize),
                .host_we    (db_hit && !db_is_cq && (db_qid == QID_W'(q))),
                .host_val   (db_data),
                .step       (sq_pop && (sq_pop_qid == QID_W'(q))),
                .head       (sq_head_a[q]),
                .tail       (sq_tail_a[q]),
                .empty      (sq_empty[q]),
                .full       (sq_full[q]),
                .host_reject(sq_rej[q])
            );

            dbq_ring #(.HOST_OWNS_TAIL(1'b0)) u_cq (
                .clk        (clk),
                .rst        (rst),
                .resize     (resize_q),
                .new_size   (cfg_cq_qsize),
                .host_we    (db_hit && db_is_cq && (db_qid == QID_W'(q))),
                .host_val   (db_data),
                .step       (cq_push && (cq_push_qid == QID_W'(q))),
                .head       (cq_head_a[q]),
                .tail       (cq_tail_a[q]),
                .empty      (cq_empty[q]),
                .full       (cq_full[q]),
                .host_reject(cq_rej[q])
            );
        end
    endgenerate

    always_comb begin
        fl_d         = fl_q;
        fl_d.db_err  = fl_q.db_err | (|sq_rej) | (|cq_rej);
        fl_d.cfg_err = fl_q.cfg_err | (cfg_we && !cfg_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign obs_ok      = ({1'b0, obs_qid} < QCOUNT);
    assign obs_sq_head = obs_ok ? sq_head_a[obs_qid] : '0;
    assign obs_sq_tail = obs_ok ? sq_tail_a[obs_qid] : '0;
    assign obs_cq_head = obs_ok ? cq_head_a[obs_qid] : '0;
    assign obs_cq_tail = obs_ok ? cq_tail_a[obs_qid] : '0;
    assign db_err      = fl_q.db_err;
    assign cfg_err     = fl_q.cfg_err;

    assert_db_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        db_err |=> db_err);

    assert_cfg_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_admin_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_qid == '0) && (cfg_sq_qsize > ADMIN_MAX_ZB)) |=> cfg_err);

    assert_stray_addr_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (db_we && !db_hit && !db_err) |=> !db_err);
endmodule

// File: tb/dbq_tracker_test.sv
module dbq_tracker_test;
    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [QW-1:0] cfg_qid = '0;
    logic [15:0]   cfg_sq_qsize = '0;
    logic [15:0]   cfg_cq_qsize = '0;
    logic          db_we = 1'b0;
    logic [AW-1:0] db_addr = '0;
    logic [15:0]   db_data = '0;
    logic          sq_pop = 1'b0;
    logic [QW-1:0] sq_pop_qid = '0;
    logic          cq_push = 1'b0;
    logic [QW-1:0] cq_push_qid = '0;
    logic [QW-1:0] obs_qid = '0;
    logic [15:0]   obs_sq_head, obs_sq_tail, obs_cq_head, obs_cq_tail;
    logic [NQ-1:0] sq_empty, sq_full, cq_empty, cq_full;
    logic          db_err, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    // reference model state
    int m_ssz[NQ], m_csz[NQ], m_sh[NQ], m_st[NQ], m_ch[NQ], m_ct[NQ];
    bit m_dberr, m_cfgerr;

    always #5 clk = ~clk;

    dbq_tracker #(.NUM_Q(NQ), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_qid(cfg_qid),
        .cfg_sq_qsize(cfg_sq_qsize), .cfg_cq_qsize(cfg_cq_qsize),
        .db_we(db_we), .db_addr(db_addr), .db_data(db_data),
        .sq_pop(sq_pop), .sq_pop_qid(sq_pop_qid),
        .cq_push(cq_push), .cq_push_qid(cq_push_qid),
        .obs_qid(obs_qid),
        .obs_sq_head(obs_sq_head), .obs_sq_tail(obs_sq_tail),
        .obs_cq_head(obs_cq_head), .obs_cq_tail(obs_cq_tail),
        .sq_empty(sq_empty), .sq_full(sq_full),
        .cq_empty(cq_empty), .cq_full(cq_full),
        .db_err(db_err), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rdist(input int a, input int b, input int n);
        return ((a - b) % n + n) % n;
    endfunction

    // reference model, steps on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin
                m_ssz[q] = 2; m_csz[q] = 2;
                m_sh[q] = 0; m_st[q] = 0; m_ch[q] = 0; m_ct[q] = 0;
            end
            m_dberr = 0; m_cfgerr = 0;
        end else begin
            bit legal;
            int a, dq, dk;
            bit dv;
            legal = cfg_sq_qsize != 0 && cfg_cq_qsize != 0 &&
                    (cfg_qid != 0 || (cfg_sq_qsize <= 4095 && cfg_cq_qsize <= 4095));
            if (cfg_we && !legal) m_cfgerr = 1;
            a  = int'(db_addr);
            dv = db_we && a >= 4096 && a < 4096 + NQ * 16 && (a % 8) == 0;
            dq = (a - 4096) / 16;
            dk = ((a - 4096) / 8) % 2;
            for (int q = 0; q < NQ; q++) begin
                int n_s, n_c, osh, ost, och, oct, v;
                n_s = m_ssz[q]; n_c = m_csz[q];
                osh = m_sh[q]; ost = m_st[q]; och = m_ch[q]; oct = m_ct[q];
                v = int'(db_data);
                if (cfg_we && legal && int'(cfg_qid) == q) begin
                    m_ssz[q] = int'(cfg_sq_qsize) + 1;
                    m_csz[q] = int'(cfg_cq_qsize) + 1;
                    m_sh[q] = 0; m_st[q] = 0; m_ch[q] = 0; m_ct[q] = 0;
                end else begin
                    if (dv && dq == q && dk == 0) begin
                        if (v < n_s && rdist(v, osh, n_s) >= rdist(ost, osh, n_s)) m_st[q] = v;
                        else m_dberr = 1;
                    end
                    if (dv && dq == q && dk == 1) begin
                        if (v < n_c && rdist(v, och, n_c) <= rdist(oct, och, n_c)) m_ch[q] = v;
                        else m_dberr = 1;
                    end
                    if (sq_pop && int'(sq_pop_qid) == q && ost != osh)
                        m_sh[q] = (osh + 1) % n_s;
                    if (cq_push && int'(cq_push_qid) == q && rdist(oct, och, n_c) < n_c - 1)
                        m_ct[q] = (oct + 1) % n_c;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (live && !rst) begin
            int oq;
            for (int q = 0; q < NQ; q++) begin
                chk("R10", "sq_empty", 32'(sq_empty[q]), 32'(m_sh[q] == m_st[q]));
                chk("R10", "sq_full",  32'(sq_full[q]),
                    32'(rdist(m_st[q], m_sh[q], m_ssz[q]) == m_ssz[q] - 1));
                chk("R10", "cq_empty", 32'(cq_empty[q]), 32'(m_ch[q] == m_ct[q]));
                chk("R10", "cq_full",  32'(cq_full[q]),
                    32'(rdist(m_ct[q], m_ch[q], m_csz[q]) == m_csz[q] - 1));
            end
            oq = int'(obs_qid);
            chk("R8", "sq_head", 32'(obs_sq_head), 32'(m_sh[oq]));
            chk("R5", "sq_tail", 32'(obs_sq_tail), 32'(m_st[oq]));
            chk("R6", "cq_head", 32'(obs_cq_head), 32'(m_ch[oq]));
            chk("R9", "cq_tail", 32'(obs_cq_tail), 32'(m_ct[oq]));
            chk("R7", "db_err",  32'(db_err),  32'(m_dberr));
            chk("R3", "cfg_err", 32'(cfg_err), 32'(m_cfgerr));
        end
    end

    task automatic strobes_off();
        cfg_we = 0; db_we = 0; sq_pop = 0; cq_push = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        strobes_off();
    endtask

    task automatic do_cfg(input int q, input int s, input int c);
        @(posedge clk); #1;
        cfg_we = 1; cfg_qid = QW'(q); cfg_sq_qsize = 16'(s); cfg_cq_qsize = 16'(c);
        tick();
    endtask

    task automatic do_db(input int addr, input int v);
        @(posedge clk); #1;
        db_we = 1; db_addr = AW'(addr); db_data = 16'(v);
        tick();
    endtask

    task automatic do_pop(input int q);
        @(posedge clk); #1;
        sq_pop = 1; sq_pop_qid = QW'(q);
        tick();
    endtask

    task automatic do_push(input int q);
        @(posedge clk); #1;
        cq_push = 1; cq_push_qid = QW'(q);
        tick();
    endtask

    task automatic look(input int q, input string req,
                        input int sh, input int st, input int ch, input int ct);
        obs_qid = QW'(q);
        @(negedge clk);
        chk(req, "obs sq_head", 32'(obs_sq_head), 32'(sh));
        chk(req, "obs sq_tail", 32'(obs_sq_tail), 32'(st));
        chk(req, "obs cq_head", 32'(obs_cq_head), 32'(ch));
        chk(req, "obs cq_tail", 32'(obs_cq_tail), 32'(ct));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 0; live = 1;
        // R1 reset state
        look(0, "R1", 0, 0, 0, 0);
        chk("R1", "sq_empty", 32'(sq_empty), 32'hF);
        chk("R1", "sq_full", 32'(sq_full), 0);
        chk("R1", "errors", 32'({db_err, cfg_err}), 0);

        // R2: q1 becomes 4 submission entries and 3 completion entries
        do_cfg(1, 3, 2);
        look(1, "R2", 0, 0, 0, 0);
        // R11: doorbell not visible before its capturing edge
        @(posedge clk); #1;
        db_we = 1; db_addr = AW'(32'h1010); db_data = 16'd3;
        @(negedge clk);
        chk("R11", "tail before edge", 32'(obs_sq_tail), 0);
        tick();
        @(negedge clk);
        chk("R11", "tail after edge", 32'(obs_sq_tail), 3);
        chk("R2", "sq_full at 3 of 4", 32'(sq_full[1]), 1);

        // R4: stray addresses
        do_db(32'h1014, 0);
        do_db(32'h1040, 0);
        do_db(32'h0FF0, 0);
        look(1, "R4", 0, 3, 0, 0);
        chk("R4", "db_err", 32'(db_err), 0);

        // R8: three pops, then pop on empty
        do_pop(1); do_pop(1); do_pop(1);
        look(1, "R8", 3, 3, 0, 0);
        chk("R8", "sq_empty", 32'(sq_empty[1]), 1);
        do_pop(1);
        look(1, "R8", 3, 3, 0, 0);

        // R5: wrapped tail accepted
        do_db(32'h1010, 1);
        look(1, "R5", 3, 1, 0, 0);
        // R7: backward tail rejected
        do_db(32'h1010, 0);
        look(1, "R7", 3, 1, 0, 0);
        chk("R7", "db_err", 32'(db_err), 1);
        // R5: value beyond ring rejected
        do_db(32'h1010, 4);
        look(1, "R5", 3, 1, 0, 0);

        // R9: completion ring of 3 fills after two posts
        do_push(1); do_push(1); do_push(1);
        look(1, "R9", 3, 1, 0, 2);
        chk("R9", "cq_full", 32'(cq_full[1]), 1);
        // R6: free one, then reject a head beyond the tail
        do_db(32'h1018, 1);
        look(1, "R6", 3, 1, 1, 2);
        do_db(32'h1018, 0);
        look(1, "R6", 3, 1, 1, 2);

        // R3: admin limit, zero size, and a full-range I/O ring
        do_cfg(0, 4096, 1);
        chk("R3", "cfg_err admin", 32'(cfg_err), 1);
        do_db(32'h1000, 1);
        do_db(32'h1000, 0);
        look(0, "R3", 0, 1, 0, 0);
        do_cfg(3, 0, 5);
        do_db(32'h1030, 2);
        look(3, "R3", 0, 0, 0, 0);
        do_cfg(2, 65535, 65535);
        do_db(32'h1020, 40000);
        look(2, "R3", 0, 40000, 0, 0);

        // R12: configuration beats same-cycle doorbell and pop
        @(posedge clk); #1;
        cfg_we = 1; cfg_qid = 2'd1; cfg_sq_qsize = 16'd3; cfg_cq_qsize = 16'd2;
        sq_pop = 1; sq_pop_qid = 2'd1;
        db_we = 1; db_addr = AW'(32'h1010); db_data = 16'd2;
        tick();
        look(1, "R12", 0, 0, 0, 0);
        do_db(32'h1010, 2);
        @(posedge clk); #1;
        sq_pop = 1; sq_pop_qid = 2'd1;
        db_we = 1; db_addr = AW'(32'h1010); db_data = 16'd3;
        tick();
        look(1, "R12", 1, 3, 0, 0);

        // random traffic checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int q, k, r;
            @(posedge clk); #1;
            strobes_off();
            obs_qid = QW'(i % NQ);
            if ($urandom_range(0, 39) == 0) begin
                cfg_we = 1;
                cfg_qid = QW'($urandom_range(0, NQ - 1));
                r = $urandom_range(0, 9);
                cfg_sq_qsize = (r == 0) ? 16'd5000 : 16'($urandom_range(0, 5));
                cfg_cq_qsize = 16'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 2) == 0) begin
                q = $urandom_range(0, NQ - 1);
                k = $urandom_range(0, 1);
                r = $urandom_range(0, 9);
                db_we = 1;
                db_addr = (r == 0) ? AW'(32'h1004 + 16 * q) :
                          (r == 1) ? AW'(32'h1000 + 16 * NQ) :
                                     AW'(32'h1000 + 16 * q + 8 * k);
                db_data = 16'($urandom_range(0, 6));
            end
            if ($urandom_range(0, 2) == 0) begin
                sq_pop = 1; sq_pop_qid = QW'($urandom_range(0, NQ - 1));
            end
            if ($urandom_range(0, 2) == 0) begin
                cq_push = 1; cq_push_qid = QW'($urandom_range(0, NQ - 1));
            end
        end
        tick();
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule